// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test-access logic for a chip's boundary-scan chain. A 16-state controller, clocked by the test clock and steered by the mode-select input, walks the standard capture, shift and update sequence. It holds a 3-bit instruction register, a one-bit bypass register and a 32-bit identification register. The decoded instruction picks the register that sits between the serial input and the serial output. When a boundary instruction is active, the block drives select, capture, shift and update strobes to an external boundary register, plus a mode flag that hands the pins to that register's update stage.

The opcode map is sparse and redundant. Three codes select bypass, two codes select the pin-driving external test, and a single code serves both for sampling the pins and for preloading the chain. Any code with no assigned meaning acts as bypass. A compliance-enable input gates the whole function. While it is low, the serial output stays disabled, no strobe is raised and the controller is held in its reset state.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The controller enters Test-Logic-Reset when trst_n is low, or after five rising test-clock edges with tms high from any state. In that state the active instruction is IDCODE (binary 010).
- R2: In Capture-IR the instruction shift register loads 001. It shifts LSB first toward tdo, so the first three bits out of an IR scan are 1, 0, 0.
- R3: A newly shifted instruction takes effect only on the falling test-clock edge in Update-IR. Shifting and pausing in the IR path leave the active instruction unchanged.
- R4: Codes 100, 110 and 111, and the unassigned code 101, place the one-bit bypass register on the scan path. It captures 0, so a DR scan returns 0 first and then the input delayed by one bit.
- R5: Code 010 (IDCODE) captures the 32-bit word {version[3:0], part[15:0], manufacturer[10:0], 1'b1} in Capture-DR and shifts it out LSB first.
- R6: Codes 000 and 011 (external test) connect bsr_tdo to the scan path and raise extest_mode.
- R7: Code 001 (sample/preload) connects bsr_tdo to the scan path and keeps extest_mode low.
- R8: With a boundary instruction active, bsr_sel is high, and bsr_capture, bsr_shift and bsr_update are high exactly in Capture-DR, Shift-DR and Update-DR. With bypass or IDCODE active, all four stay low.
- R9: tdo changes only on the falling test-clock edge. tdo_oe is high only while the controller is in Shift-IR or Shift-DR.
- R10: While comply_en is 0, tdo_oe, extest_mode and all boundary strobes are low, and the controller is held in Test-Logic-Reset.
- R11: The test clock may be stopped high or low during a scan without loss of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| comply_en | input | 1 | Compliance enable; the test logic owns the pins only while high |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_sel | output | 1 | Boundary register is on the scan path |
| bsr_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bsr_shift | output | 1 | Boundary shift enable (Shift-DR) |
| bsr_update | output | 1 | Boundary update strobe (Update-DR) |
| extest_mode | output | 1 | Pins driven from the boundary update stage |

## Verification
The hardest conditions to reach are those where the active instruction must not move. One is a scan that has shifted a new code and is parked in Pause-IR. Another is a scan frozen with the test clock stopped partway through a shift. The stimulus loads external test, shifts a bypass code, parks in Pause-IR and checks that the mode flag still holds before Update-IR completes the change. It also halts the clock once high and once low in the middle of a 32-bit identification readout and checks that the full word still arrives intact. A table walks all eight opcodes, so the unassigned code and every redundant alias are each observed on the serial output.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   localparam int ID_W = 32;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_IDLE,
      ST_DR_SEL,
      ST_DR_CAP,
      ST_DR_SHIFT,
      ST_DR_EXIT1,
      ST_DR_PAUSE,
      ST_DR_EXIT2,
      ST_DR_UPD,
      ST_IR_SEL,
      ST_IR_CAP,
      ST_IR_SHIFT,
      ST_IR_EXIT1,
      ST_IR_PAUSE,
      ST_IR_EXIT2,
      ST_IR_UPD
   } tap_state_e;

   typedef enum logic [1:0] {
      OPC_BYPASS,
      OPC_SAMPLE,
      OPC_EXTEST,
      OPC_IDCODE
   } op_class_e;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   input  logic       hold_reset,
   output tap_state_e st
);

   tap_state_e nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
         ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
         ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
         ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
         ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
         ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
         ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
         ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
         ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
         ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
         ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
         ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
         default:     nxt = ST_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)         st <= ST_RESET;
      else if (hold_reset) st <= ST_RESET;
      else                 st <= nxt;
   end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
   import scan_tap_pkg::*;
#(
   parameter int                IR_LEN      = 3,
   parameter logic [IR_LEN-1:0] CAPTURE_PAT = 'b001,
   parameter logic [IR_LEN-1:0] RESET_CODE  = 'b010
)(
   input  logic              tck,
   input  logic              trst_n,
   input  tap_state_e        st,
   input  logic              tdi,
   output logic [IR_LEN-1:0] instr,
   output logic              ir_tdo
);

   logic [IR_LEN-1:0] sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                sr <= CAPTURE_PAT;
      else if (st == ST_IR_CAP)   sr <= CAPTURE_PAT;
      else if (st == ST_IR_SHIFT) sr <= {tdi, sr[IR_LEN-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)              instr <= RESET_CODE;
      else if (st == ST_RESET)  instr <= RESET_CODE;
      else if (st == ST_IR_UPD) instr <= sr;
   end

   assign ir_tdo = sr[0];

endmodule

// File: rtl/scan_tap_decode.sv
module scan_tap_decode
   import scan_tap_pkg::*;
#(
   parameter int                IR_LEN      = 3,
   parameter bit                ID_PRESENT  = 1'b1,
   parameter logic [IR_LEN-1:0] OP_EXTEST_A = 'b000,
   parameter logic [IR_LEN-1:0] OP_EXTEST_B = 'b011,
   parameter logic [IR_LEN-1:0] OP_SAMPLE   = 'b001,
   parameter logic [IR_LEN-1:0] OP_IDCODE   = 'b010
)(
   input  logic [IR_LEN-1:0] instr,
   output op_class_e         op
);

   always_comb begin
      op = OPC_BYPASS;
      if (instr == OP_EXTEST_A || instr == OP_EXTEST_B)
         op = OPC_EXTEST;
      else if (instr == OP_SAMPLE)
         op = OPC_SAMPLE;
      else if (ID_PRESENT && instr == OP_IDCODE)
         op = OPC_IDCODE;
   end

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
   import scan_tap_pkg::*;
#(
   parameter bit              ID_PRESENT = 1'b1,
   parameter logic [ID_W-1:0] ID_WORD    = 32'h0000_0001
)(
   input  logic       tck,
   input  logic       trst_n,
   input  tap_state_e st,
   input  op_class_e  op,
   input  logic       tdi,
   output logic       byp_tdo,
   output logic       id_tdo
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                byp_tdo <= 1'b0;
      else if (st == ST_DR_CAP)   byp_tdo <= 1'b0;
      else if (st == ST_DR_SHIFT) byp_tdo <= tdi;
   end

   generate
      if (ID_PRESENT) begin : g_id
         logic [ID_W-1:0] id_sr;
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)
               id_sr <= ID_WORD;
            else if (op == OPC_IDCODE && st == ST_DR_CAP)
               id_sr <= ID_WORD;
            else if (op == OPC_IDCODE && st == ST_DR_SHIFT)
               id_sr <= {tdi, id_sr[ID_W-1:1]};
         end
         assign id_tdo = id_sr[0];
      end else begin : g_no_id
         assign id_tdo = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
   import scan_tap_pkg::*;
#(
   parameter int                IR_LEN      = 3,
   parameter bit                ID_PRESENT  = 1'b1,
   parameter int                VER_W       = 4,
   parameter int                PART_W      = 16,
   parameter int                MFR_W       = 11,
   parameter logic [VER_W-1:0]  ID_VERSION  = 4'h3,
   parameter logic [PART_W-1:0] ID_PART     = 16'hC6A1,
   parameter logic [MFR_W-1:0]  ID_MFR      = 11'h1D5,
   parameter logic [IR_LEN-1:0] CAPTURE_PAT = 'b001,
   parameter logic [IR_LEN-1:0] OP_EXTEST_A = 'b000,
   parameter logic [IR_LEN-1:0] OP_EXTEST_B = 'b011,
   parameter logic [IR_LEN-1:0] OP_SAMPLE   = 'b001,
   parameter logic [IR_LEN-1:0] OP_IDCODE   = 'b010
)(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   input  logic comply_en,
   input  logic bsr_tdo,
   output logic tdo,
   output logic tdo_oe,
   output logic bsr_sel,
   output logic bsr_capture,
   output logic bsr_shift,
   output logic bsr_update,
   output logic extest_mode
);

   localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

   generate
      if (IR_LEN < 2) begin : g_bad_ir
         $error("scan_tap_ctrl: IR_LEN must be at least 2");
      end
      if (VER_W + PART_W + MFR_W != ID_W - 1) begin : g_bad_id
         $error("scan_tap_ctrl: identification fields must fill 31 bits");
      end
      if (CAPTURE_PAT[1:0] != 2'b01) begin : g_bad_cap
         $error("scan_tap_ctrl: capture pattern must end in 01");
      end
   endgenerate

   tap_state_e        st_q;
   op_class_e         op_q;
   logic [IR_LEN-1:0] instr_q;
   logic              ir_tdo;
   logic              byp_tdo;
   logic              id_tdo;
   logic              ser_out;
   logic              tdo_q;
   logic              oe_q;
   logic              bnd_op;

   scan_tap_fsm u_fsm (
      .tck        (tck),
      .trst_n     (trst_n),
      .tms        (tms),
      .hold_reset (!comply_en),
      .st         (st_q)
   );

   scan_tap_ir #(
      .IR_LEN      (IR_LEN),
      .CAPTURE_PAT (CAPTURE_PAT),
      .RESET_CODE  (OP_IDCODE)
   ) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .st     (st_q),
      .tdi    (tdi),
      .instr  (instr_q),
      .ir_tdo (ir_tdo)
   );

   scan_tap_decode #(
      .IR_LEN      (IR_LEN),
      .ID_PRESENT  (ID_PRESENT),
      .OP_EXTEST_A (OP_EXTEST_A),
      .OP_EXTEST_B (OP_EXTEST_B),
      .OP_SAMPLE   (OP_SAMPLE),
      .OP_IDCODE   (OP_IDCODE)
   ) u_dec (
      .instr (instr_q),
      .op    (op_q)
   );

   scan_tap_dr #(
      .ID_PRESENT (ID_PRESENT),
      .ID_WORD    (ID_WORD)
   ) u_dr (
      .tck     (tck),
      .trst_n  (trst_n),
      .st      (st_q),
      .op      (op_q),
      .tdi     (tdi),
      .byp_tdo (byp_tdo),
      .id_tdo  (id_tdo)
   );

   // serial path selection
   always_comb begin
      if (st_q == ST_IR_SHIFT) begin
         ser_out = ir_tdo;
      end else begin
         unique case (op_q)
            OPC_BYPASS: ser_out = byp_tdo;
            OPC_IDCODE: ser_out = id_tdo;
            default:    ser_out = bsr_tdo;
         endcase
      end
   end

   // output retimed on the falling edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         tdo_q <= ser_out;
         oe_q  <= (st_q == ST_IR_SHIFT) || (st_q == ST_DR_SHIFT);
      end
   end

   assign bnd_op      = (op_q == OPC_SAMPLE) || (op_q == OPC_EXTEST);
   assign tdo         = tdo_q;
   assign tdo_oe      = oe_q & comply_en;
   assign bsr_sel     = comply_en & bnd_op;
   assign bsr_capture = bsr_sel & (st_q == ST_DR_CAP);
   assign bsr_shift   = bsr_sel & (st_q == ST_DR_SHIFT);
   assign bsr_update  = bsr_sel & (st_q == ST_DR_UPD);
   assign extest_mode = comply_en & (op_q == OPC_EXTEST);

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
   import scan_tap_pkg::*;
(
   input logic       tck,
   input logic       trst_n,
   input logic       comply_en,
   input logic       tdo_oe,
   input logic       bsr_sel,
   input logic       bsr_capture,
   input logic       bsr_shift,
   input logic       bsr_update,
   input logic       extest_mode,
   input tap_state_e st,
   input op_class_e  op,
   input logic       ir_tdo,
   input logic       byp_tdo
);

   p_tlr_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_RESET) |-> (op == OPC_IDCODE));

   p_ir_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_IR_CAP) |=> (ir_tdo == 1'b1));

   p_instr_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
      (st != ST_IR_UPD && st != ST_RESET) |-> $stable(op));

   p_bypass_zero_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_DR_CAP) |=> (byp_tdo == 1'b0));

   p_oe_in_shift_r9: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (st == ST_IR_SHIFT || st == ST_DR_SHIFT));

   p_quiet_noncomply_r10: assert property (@(posedge tck) disable iff (!trst_n)
      !comply_en |-> !(tdo_oe || bsr_sel || bsr_capture || bsr_shift
                       || bsr_update || extest_mode));

endmodule

bind scan_tap_ctrl scan_tap_chk u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .comply_en   (comply_en),
   .tdo_oe      (tdo_oe),
   .bsr_sel     (bsr_sel),
   .bsr_capture (bsr_capture),
   .bsr_shift   (bsr_shift),
   .bsr_update  (bsr_update),
   .extest_mode (extest_mode),
   .st          (st_q),
   .op          (op_q),
   .ir_tdo      (ir_tdo),
   .byp_tdo     (byp_tdo)
);

// File: tb/sim_scan_tap_ctrl.sv
module sim_scan_tap_ctrl;

   localparam int TCK_PERIOD = 100;
   localparam logic [31:0] EXP_ID = {4'h3, 16'hC6A1, 11'h1D5, 1'b1};

   // {opcode[2:0], kind[1:0]}: kind 0 bypass, 1 sample, 2 extest, 3 idcode
   localparam logic [4:0] VEC [8] = '{
      {3'b000, 2'd2}, {3'b001, 2'd1}, {3'b010, 2'd3}, {3'b011, 2'd2},
      {3'b100, 2'd0}, {3'b101, 2'd0}, {3'b110, 2'd0}, {3'b111, 2'd0}
   };

   logic tck = 1'b0;
   logic tck_run = 1'b1;
   logic trst_n, tms, tdi, comply_en, bsr_tdo;
   logic tdo, tdo_oe, bsr_sel, bsr_capture, bsr_shift, bsr_update, extest_mode;

   logic obs_tdo, obs_oe, obs_shift, obs_cap, obs_upd, post_tdo;
   int   stop_now = 0;
   int   checks = 0;
   int   errors = 0;
   logic done = 1'b0;

   scan_tap_ctrl u0 (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .comply_en(comply_en),
      .bsr_tdo(bsr_tdo), .tdo(tdo), .tdo_oe(tdo_oe), .bsr_sel(bsr_sel),
      .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
      .extest_mode(extest_mode)
   );

   always begin
      #(TCK_PERIOD / 2);
      if (tck_run) tck = ~tck;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pause_clk();
      tck_run = 1'b0;
      #(20 * TCK_PERIOD);
      tck_run = 1'b1;
   endtask

   // one test-clock cycle: drive after the fall, sample mid-low, observe after the rise
   task automatic step(input logic m, input logic d);
      @(negedge tck);
      tms = m;
      tdi = d;
      #(TCK_PERIOD / 4);
      obs_tdo   = tdo;
      obs_oe    = tdo_oe;
      obs_shift = bsr_shift;
      obs_cap   = bsr_capture;
      obs_upd   = bsr_update;
      if (stop_now == 1) pause_clk();
      @(posedge tck);
      #1;
      post_tdo = tdo;
      if (stop_now == 2) pause_clk();
   endtask

   task automatic load_ir(input logic [2:0] code, output logic [2:0] cap_out);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 3; i++) begin
         step(i == 2, code[i]);
         cap_out[i] = obs_tdo;
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, input int stop_at,
                          input int stop_kind, output logic [31:0] dout,
                          output logic [3:0] strobes, output logic oe_all,
                          output logic fall_ok);
      logic sh_all, sh_any, cap, upd;
      dout = '0; sh_all = 1'b1; sh_any = 1'b0; oe_all = 1'b1; fall_ok = 1'b1;
      step(1, 0);
      step(0, 0);
      step(0, 0);
      cap = obs_cap;
      for (int i = 0; i < n; i++) begin
         stop_now = (i == stop_at) ? stop_kind : 0;
         step(i == n - 1, din[i]);
         stop_now = 0;
         dout[i] = obs_tdo;
         sh_all  = sh_all & obs_shift;
         sh_any  = sh_any | obs_shift;
         oe_all  = oe_all & obs_oe;
         if (post_tdo !== obs_tdo) fall_ok = 1'b0;
      end
      step(1, 0);
      step(0, 0);
      upd = obs_upd;
      strobes = {sh_all, sh_any, cap, upd};
   endtask

   initial begin
      #(TCK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [2:0]  ir_out;
      logic [31:0] dout;
      logic [3:0]  strb;
      logic        oe_all, fall_ok;
      trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; comply_en = 1'b1; bsr_tdo = 1'b1;
      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      #(TCK_PERIOD / 4);
      chk("R9 reset oe", {31'd0, tdo_oe}, 32'd0);
      chk("R1 reset extest", {31'd0, extest_mode}, 32'd0);

      // IDCODE active after reset, full word LSB first
      step(0, 0);
      scan_dr(32, 32'h0, -1, 0, dout, strb, oe_all, fall_ok);
      chk("R5 R1 idcode after reset", dout, EXP_ID);
      chk("R9 oe during shift", {31'd0, oe_all}, 32'd1);
      chk("R9 tdo moves on fall only", {31'd0, fall_ok}, 32'd1);
      chk("R9 oe idle", {31'd0, tdo_oe}, 32'd0);

      // capture pattern in the IR
      load_ir(3'b111, ir_out);
      chk("R2 ir capture", {29'd0, ir_out}, 32'd1);

      // walk every opcode
      foreach (VEC[k]) begin
         logic [2:0]  code;
         logic [1:0]  kind;
         logic [31:0] exp_out;
         string       rq;
         code = VEC[k][4:2];
         kind = VEC[k][1:0];
         load_ir(code, ir_out);
         scan_dr(8, 32'h0000_00B5, -1, 0, dout, strb, oe_all, fall_ok);
         case (kind)
            2'd0: begin rq = "R4"; exp_out = {24'd0, 8'hB5 << 1}; end
            2'd1: begin rq = "R7"; exp_out = 32'h0000_00FF; end
            2'd2: begin rq = "R6"; exp_out = 32'h0000_00FF; end
            default: begin rq = "R5"; exp_out = {24'd0, EXP_ID[7:0]}; end
         endcase
         chk($sformatf("%s data code %b", rq, code), dout & 32'hFF, exp_out);
         chk($sformatf("%s extest code %b", rq, code), {31'd0, extest_mode},
             {31'd0, kind == 2'd2});
         chk($sformatf("R8 strobes code %b", code), {28'd0, strb},
             (kind == 2'd1 || kind == 2'd2) ? 32'hF : 32'h0);
      end

      // R3: instruction held through shift and pause
      load_ir(3'b000, ir_out);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      step(0, 1); step(0, 1); step(1, 1);
      step(0, 0);
      #(TCK_PERIOD / 4);
      chk("R3 held in pause", {31'd0, extest_mode}, 32'd1);
      step(1, 0); step(1, 0);
      chk("R3 held until update fall", {31'd0, extest_mode}, 32'd1);
      step(0, 0);
      chk("R3 applied after update", {31'd0, extest_mode}, 32'd0);

      // R1: five tms-high cycles reach reset
      load_ir(3'b011, ir_out);
      chk("R1 extest loaded", {31'd0, extest_mode}, 32'd1);
      repeat (5) step(1, 0);
      chk("R1 tms reset clears extest", {31'd0, extest_mode}, 32'd0);
      step(0, 0);
      scan_dr(32, 32'h0, -1, 0, dout, strb, oe_all, fall_ok);
      chk("R1 idcode after tms reset", dout, EXP_ID);

      // R10: compliance low
      load_ir(3'b000, ir_out);
      @(negedge tck);
      comply_en = 1'b0;
      #1;
      chk("R10 extest gated", {31'd0, extest_mode}, 32'd0);
      scan_dr(8, 32'h0, -1, 0, dout, strb, oe_all, fall_ok);
      chk("R10 no strobes", {28'd0, strb}, 32'd0);
      chk("R10 tdo_oe low", {31'd0, oe_all | tdo_oe}, 32'd0);
      @(negedge tck);
      comply_en = 1'b1;
      step(0, 0);
      scan_dr(32, 32'h0, -1, 0, dout, strb, oe_all, fall_ok);
      chk("R10 held in reset gives idcode", dout, EXP_ID);

      // R11: clock stopped low then high mid-scan
      scan_dr(32, 32'h0, 5, 1, dout, strb, oe_all, fall_ok);
      chk("R11 stop low", dout, EXP_ID);
      scan_dr(32, 32'h0, 17, 2, dout, strb, oe_all, fall_ok);
      chk("R11 stop high", dout, EXP_ID);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule